// File: doc/BRIEF.md
# Keyed Watchdog Timer with Selectable Time-Out

This block is a watchdog for a system that runs off a clock enable. Each enabled cycle advances a prescaler. Prescaler overflows advance a time-out counter, and a 3-bit rate code sets how many overflows make up one time-out. Software keeps the watchdog quiet by writing an ordered two-byte key to a service location: first 0x55, then 0xAA. Any number of other bus accesses may fall between the two key writes.

If the period runs out before a complete key arrives, the block raises a one-cycle reset request. Any byte other than the two keys written to the service location raises the request at once. The rate code can be written only once after reset in normal mode, and freely in special mode. In special mode a test input shortens the prescaler to its two lowest stages, so a time-out can be reached in a few cycles.

Top module: `keyed_watchdog`

## Requirements
- R1: With rate code c from 1 to 7, the block counts enabled cycles from the last clear. The time-out occurs on the enabled cycle numbered 2^(PRE_BITS+k), where k is 0, 2, 4, 6, 8, 9 or 10 for c = 1 to 7. With the default PRE_BITS=13 the totals are 2^13 to 2^23.
- R2: With rate code 0 the counters are held cleared, and no time-out reset occurs for any length of time.
- R3: The rate code sits in bits [2:0] at address 0 and reads back there as {5'b0, code}. Its reset value is 0. In normal mode (special_i=0) only the first write after reset takes effect. In special mode every write takes effect.
- R4: The service location (address 1) always reads 0x00.
- R5: A write of 0xAA to address 1 services the watchdog when a 0x55 write has come before it. Servicing clears both counters and the armed state. Other accesses may fall between the two writes, and a repeated 0x55 keeps the block armed. A 0xAA write without a prior 0x55 has no effect.
- R6: Writing any byte other than 0x55 or 0xAA to address 1 causes a reset request, including when the rate code is 0.
- R7: The reset request is a registered pulse, high for one cycle, starting the cycle after its cause. The cause also clears the counters and the armed state, so the next period is counted in full.
- R8: When bypass_i=1 and special_i=1, the prescaler period becomes 4 enabled cycles, so the time-out is 4·2^k cycles. In normal mode bypass_i has no effect.
- R9: The counters advance only on cycles with e_en_i=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| e_en_i | input | 1 | Count enable (system clock enable) |
| addr_i | input | ADDR_W | Register address: 0 rate code, 1 service |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, one write per cycle high |
| rdata_o | output | 8 | Read data for addr_i |
| special_i | input | 1 | 1 selects special mode |
| bypass_i | input | 1 | Prescaler test bypass, honoured in special mode |
| wdog_rst_o | output | 1 | Watchdog reset request pulse |

## Verification
The bench builds the block with PRE_BITS=4 instead of 13. This puts the time-out of every rate code within a few thousand cycles, up to 16384 cycles for code 7. The exact interval between pulses can then be measured for the short codes, the long codes, a gated count enable, and the bypassed prescaler in both modes. The key sequences, the write-once lock and the off code are compared cycle by cycle against a behavioural model.

// File: rtl/kwdog_pkg.sv
`timescale 1ns/1ps
package kwdog_pkg;
  localparam int RATE_W = 3;
  localparam int DATA_W = 8;
  // widest time-out counter: largest extra exponent (code 7)
  localparam int CNT_W  = 10;
  localparam logic [DATA_W-1:0] KEY_ARM  = 8'h55;
  localparam logic [DATA_W-1:0] KEY_FIRE = 8'hAA;

  typedef enum logic {SEQ_IDLE, SEQ_ARMED} seq_t;

  // extra binary exponent beyond the prescaler for each rate code
  function automatic int unsigned ext_exp(logic [RATE_W-1:0] code);
    case (code)
      3'd1:    return 0;
      3'd2:    return 2;
      3'd3:    return 4;
      3'd4:    return 6;
      3'd5:    return 8;
      3'd6:    return 9;
      3'd7:    return 10;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/kwdog_prescaler.sv
`timescale 1ns/1ps
module kwdog_prescaler #(
  parameter int PRE_BITS  = 13,
  parameter int KEEP_BITS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  input  logic bypass_i,
  output logic tick_o
);
  logic [PRE_BITS-1:0] pre_q, pre_d;
  logic                wrap_full, wrap_short;

  assign wrap_full  = &pre_q;
  assign wrap_short = &pre_q[KEEP_BITS-1:0];
  assign tick_o     = en_i && (bypass_i ? wrap_short : wrap_full);

  always_comb begin
    pre_d = pre_q;
    if (clr_i)     pre_d = '0;
    else if (en_i) pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_d;
  end
endmodule

// File: rtl/kwdog_timeout.sv
`timescale 1ns/1ps
module kwdog_timeout
  import kwdog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              clr_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, lim_m1;
  logic             off;

  assign off      = (rate_i == '0);
  assign lim_m1   = CNT_W'((32'd1 << ext_exp(rate_i)) - 32'd1);
  assign expire_o = tick_i && !off && (cnt_q == lim_m1);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i || off) cnt_d = '0;
    else if (tick_i)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R2: the off code holds the counter cleared
  p_off_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_i == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/kwdog_keyseq.sv
`timescale 1ns/1ps
module kwdog_keyseq
  import kwdog_pkg::*;
#(
  parameter int                ADDR_W    = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] SVC_ADDR  = ADDR_W'(1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              special_i,
  input  logic              clr_seq_i,
  output logic [RATE_W-1:0] rate_o,
  output logic              svc_ok_o,
  output logic              bad_key_o,
  output logic              armed_o,
  output logic [DATA_W-1:0] rdata_o
);
  seq_t              st_q, st_d;
  logic [RATE_W-1:0] rate_q, rate_d;
  logic              lock_q, lock_d;
  logic              svc_wr, ctl_wr, is_arm, is_fire;

  assign svc_wr    = we_i && (addr_i == SVC_ADDR);
  assign ctl_wr    = we_i && (addr_i == CTRL_ADDR);
  assign is_arm    = (wdata_i == KEY_ARM);
  assign is_fire   = (wdata_i == KEY_FIRE);
  assign bad_key_o = svc_wr && !is_arm && !is_fire;
  assign svc_ok_o  = svc_wr && is_fire && (st_q == SEQ_ARMED);
  assign armed_o   = (st_q == SEQ_ARMED);
  assign rate_o    = rate_q;
  assign rdata_o   = (addr_i == CTRL_ADDR) ? {{(DATA_W-RATE_W){1'b0}}, rate_q} : '0;

  always_comb begin
    st_d = st_q;
    if (clr_seq_i)            st_d = SEQ_IDLE;
    else if (svc_wr && is_arm) st_d = SEQ_ARMED;
    else if (svc_ok_o)        st_d = SEQ_IDLE;
  end

  always_comb begin
    rate_d = rate_q;
    lock_d = lock_q;
    if (ctl_wr && (special_i || !lock_q)) begin
      rate_d = wdata_i[RATE_W-1:0];
      lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SEQ_IDLE;
      rate_q <= '0;
      lock_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rate_q <= rate_d;
      lock_q <= lock_d;
    end
  end

  // R3: once written, the code cannot change while in normal mode
  p_rate_locked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !special_i) |=> $stable(rate_q));
endmodule

// File: rtl/keyed_watchdog.sv
`timescale 1ns/1ps
module keyed_watchdog
  import kwdog_pkg::*;
#(
  parameter int PRE_BITS    = 13,
  parameter int KEEP_BITS   = 2,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              e_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              special_i,
  input  logic              bypass_i,
  output logic              wdog_rst_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   srst_n;
  logic                   tick, expire, svc_ok, bad_key, armed, cause, rst_q;
  logic [RATE_W-1:0]      rate;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign srst_n = sync_q[SYNC_STAGES-1];

  assign cause = expire || bad_key;

  kwdog_prescaler #(.PRE_BITS(PRE_BITS), .KEEP_BITS(KEEP_BITS)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (srst_n),
    .en_i     (e_en_i),
    .clr_i    (cause || svc_ok || (rate == '0)),
    .bypass_i (bypass_i && special_i),
    .tick_o   (tick)
  );

  kwdog_timeout u_tmo (
    .clk_i    (clk_i),
    .rst_ni   (srst_n),
    .tick_i   (tick),
    .clr_i    (cause || svc_ok),
    .rate_i   (rate),
    .expire_o (expire)
  );

  kwdog_keyseq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (srst_n),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .special_i (special_i),
    .clr_seq_i (cause),
    .rate_o    (rate),
    .svc_ok_o  (svc_ok),
    .bad_key_o (bad_key),
    .armed_o   (armed),
    .rdata_o   (rdata_o)
  );

  always_ff @(posedge clk_i or negedge srst_n) begin
    if (!srst_n) rst_q <= 1'b0;
    else         rst_q <= cause;
  end
  assign wdog_rst_o = rst_q;

  // R6: a wrong key is followed by the request
  p_bad_key_r6: assert property (@(posedge clk_i) disable iff (!srst_n)
    bad_key |=> wdog_rst_o);
  // R7: the request lasts a single cycle unless a new wrong key arrives
  p_pulse_single_r7: assert property (@(posedge clk_i) disable iff (!srst_n)
    (wdog_rst_o && !bad_key) |=> !wdog_rst_o);
  // R7: the sequence state is idle while the request is high
  p_seq_clear_r7: assert property (@(posedge clk_i) disable iff (!srst_n)
    wdog_rst_o |-> !armed);
endmodule

// File: tb/keyed_watchdog_bench.sv
`timescale 1ns/1ps
module keyed_watchdog_bench;
  localparam int PRE = 4;

  logic       clk = 1'b0;
  logic       rst_n, e_en, we, special, bypass, gate;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  logic       wdog_rst;
  int         checks = 0, errors = 0, cycles = 0, pulses = 0;
  string      cur_req = "R3";

  // behavioural model
  int         m_cnt;
  logic       m_armed, m_lock, m_rst;
  logic [2:0] m_rate;

  always #2.5 clk = ~clk;

  keyed_watchdog #(.PRE_BITS(PRE)) u_keyed_watchdog (
    .clk_i(clk), .rst_ni(rst_n), .e_en_i(e_en), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .rdata_o(rdata), .special_i(special), .bypass_i(bypass),
    .wdog_rst_o(wdog_rst));

  function automatic int extra(logic [2:0] c);
    int t[8] = '{0, 0, 2, 4, 6, 8, 9, 10};
    return t[c];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_armed = 0; m_lock = 0; m_rate = 0; m_rst = 0;
    end else begin
      logic cause;
      int   pre;
      cause = 0;
      pre = (bypass && special) ? 4 : (1 << PRE);
      if (m_rate == 0) m_cnt = 0;
      else if (e_en) begin
        m_cnt++;
        if (m_cnt >= (pre << extra(m_rate))) cause = 1;
      end
      if (we && addr == 2'd1) begin
        if (wdata == 8'h55) m_armed = 1;
        else if (wdata == 8'hAA) begin
          if (m_armed) begin m_cnt = 0; m_armed = 0; end
        end else cause = 1;
      end
      if (we && addr == 2'd0 && (special || !m_lock)) begin
        m_rate = wdata[2:0]; m_lock = 1;
      end
      if (cause) begin m_cnt = 0; m_armed = 0; end
      m_rst = cause;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // cycle-by-cycle comparison with the model, away from the edge
  always @(posedge clk) begin
    #1;
    cycles++;
    if (rst_n) begin
      if (wdog_rst) pulses++;
      check(cur_req, int'(wdog_rst), int'(m_rst));
      check("R4", int'(rdata), (addr == 2'd0) ? int'(m_rate) : 0);
    end
    if (cycles > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=done", cycles);
      finish_run();
    end
  end

  always @(negedge clk) e_en <= gate ? ~e_en : 1'b1;

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0; addr = 2'd0;
  endtask

  task automatic wait_pulse();
    int n = 0;
    do begin @(posedge clk); #1; n++; end while (!wdog_rst && n < 40000);
    if (!wdog_rst) check("R1 pulse wait", 0, 1);
  endtask

  task automatic measure(string req, int exp);
    int n = 0;
    wait_pulse();
    do begin @(posedge clk); #1; n++; end while (!wdog_rst && n < 40000);
    check(req, n, exp);
  endtask

  initial begin
    int p0;
    rst_n = 0; we = 0; addr = 0; wdata = 0; special = 0; bypass = 0; gate = 0;
    e_en = 1;
    idle(4); rst_n = 1; idle(5);
    // reset state
    @(posedge clk); #1;
    check("R3 reset code", int'(rdata), 0);
    check("R7 reset request", int'(wdog_rst), 0);
    @(negedge clk); addr = 2'd1; @(posedge clk); #1;
    check("R4 service read", int'(rdata), 0);
    @(negedge clk); addr = 2'd0;

    cur_req = "R2"; p0 = pulses; idle(200);
    check("R2 off no pulse", pulses - p0, 0);
    cur_req = "R6"; p0 = pulses; wr(2'd1, 8'h12); idle(3);
    check("R6 wrong key while off", pulses - p0, 1);

    cur_req = "R1"; wr(2'd0, 3'd1);
    measure("R1 code1 period", 16);
    wr(2'd0, 3'd3); @(posedge clk); #1;
    check("R3 normal-mode rewrite ignored", int'(rdata), 1);

    cur_req = "R5"; wait_pulse(); p0 = pulses;
    for (int i = 0; i < 12; i++) begin
      wr(2'd1, 8'h55); idle(2); wr(2'd1, 8'h55); wr(2'd0, 8'h07); wr(2'd1, 8'hAA); idle(3);
    end
    check("R5 keyed service holds off", pulses - p0, 0);
    wait_pulse(); p0 = pulses;
    for (int i = 0; i < 8; i++) begin wr(2'd1, 8'hAA); idle(4); end
    check("R5 lone AA does not service", (pulses - p0) >= 2 ? 1 : 0, 1);

    cur_req = "R9"; wait_pulse(); gate = 1;
    measure("R9 gated enable period", 32);
    wait_pulse(); gate = 0;

    cur_req = "R8"; wait_pulse(); bypass = 1;
    measure("R8 bypass ignored in normal mode", 16);
    wait_pulse(); special = 1;
    measure("R8 bypass code1", 4);
    wait_pulse(); wr(2'd0, 3'd2); @(posedge clk); #1;
    check("R3 special-mode rewrite", int'(rdata), 2);
    measure("R8 bypass code2", 16);
    wait_pulse(); bypass = 0;

    cur_req = "R1";
    measure("R1 code2 period", 64);
    wait_pulse(); wr(2'd0, 3'd4);
    measure("R1 code4 period", 1024);
    wait_pulse(); wr(2'd0, 3'd6);
    measure("R1 code6 period", 8192);
    wait_pulse(); wr(2'd0, 3'd7);
    measure("R1 code7 period", 16384);

    cur_req = "R2"; wait_pulse(); wr(2'd0, 3'd0); p0 = pulses; idle(300);
    check("R2 off after running", pulses - p0, 0);
    cur_req = "R6"; p0 = pulses; wr(2'd1, 8'h55);
    @(negedge clk); addr = 2'd1; @(posedge clk); #1;
    check("R4 service read while armed", int'(rdata), 0);
    wr(2'd1, 8'h56); idle(3);
    check("R6 wrong second key", pulses - p0, 1);
    p0 = pulses; wr(2'd1, 8'h00); idle(3);
    check("R7 single pulse for zero key", pulses - p0, 1);
    idle(5);
    finish_run();
  end
endmodule